// File: doc/BRIEF.md
# Dual-Enable Synchronous Counter Digit with Carry Output

This block is a four-bit synchronous counter digit. Every flip-flop in it is clocked by the same clock edge. Each bit is a toggle stage. A bit flips on an advancing edge when all bits below it are 1, and that condition is formed as one wide AND per bit rather than a chain through the lower stages.

The count moves forward only when two enables are high together:
- The local enable is normally shared by all digits of a chain.
- The chain enable is normally fed from the carry of the next lower digit.

A build parameter selects the counting range. Binary mode counts 0 to 15. Decade mode counts 0 to 9. In decade mode the count returns from 9 to 0 on the next advancing edge; it never passes through 10.

The carry output depends on the chain enable and the terminal count only, and the local enable has no effect on it. Several digits can therefore be strung into a wider counter with no extra logic between them. The carry is formed by a single gate. An active-low synchronous clear returns the digit to zero, and so does the active-high synchronous reset. Both take priority over counting.

Top module: `cascade_counter`

## Requirements
- R1: In the cycle after `rst` is sampled high, `count` is 0.
- R2: When `clr_n` is sampled low at a clock edge, `count` is 0 after that edge, whatever the two enables are.
- R3: With `rst` low, `clr_n` high and both `en_par` and `en_chain` high at an edge, `count` becomes count+1. From the terminal value it becomes 0. The terminal value is 15 (4'b1111) in binary mode and 9 (4'b1001) in decade mode.
- R4: With `rst` low, `clr_n` high and either enable low at an edge, `count` keeps its value.
- R5: In decade mode (`MODE` = 1) `count` never exceeds 9, and 9 is followed by 0 on an advancing edge.
- R6: `carry_out` is high exactly when `en_chain` is high and `count` equals the terminal value. `en_par` has no effect on it.
- R7: Two digits of the same mode form a wider counter when both take the same `en_par` and the upper digit's `en_chain` is driven from the lower digit's `carry_out`. The pair then counts modulo 256 in binary mode or modulo 100 in decade mode, the lower digit being the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every stage, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Synchronous clear to zero, active low |
| en_par | input | 1 | Local count enable, shared along a chain |
| en_chain | input | 1 | Chain count enable; also qualifies the carry |
| count | output | 4 | Current count value |
| carry_out | output | 1 | Terminal-count carry for the next digit |

## Verification
The bound checker watches several properties on every cycle:
- reset and clear both give zero;
- an advancing edge gives the successor value and a blocked edge leaves the count unchanged;
- a decade digit stays within 0 to 9;
- the carry is low whenever the chain enable is low, and is high only at the terminal value;
- a carry together with an advancing edge is followed by zero.

What only the bench scenarios can show is the behaviour of two digits joined together. That covers the combined eight-bit and two-decade sequences across every wrap. It also covers a carry that stays high while the local enable holds the count, and long random mixes of clears and enables, all checked against a reference value for the pair.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_DECADE = 1'b1
    } count_mode_e;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic clear;
        logic advance;
    } step_ctrl_t;

    function automatic digit_t terminal_of(count_mode_e m);
        return (m == MODE_DECADE) ? digit_t'(9) : '1;
    endfunction

endpackage

// File: rtl/cnt_ctrl.sv
`timescale 1ns/1ps
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic       rst,
    input  logic       clr_n,
    input  logic       en_par,
    input  logic       en_chain,
    output step_ctrl_t ctrl
);
    always_comb begin
        ctrl.clear   = rst | ~clr_n;
        ctrl.advance = en_par & en_chain;
    end
endmodule

// File: rtl/cnt_toggle_gen.sv
`timescale 1ns/1ps
module cnt_toggle_gen
    import cnt_pkg::*;
#(
    parameter count_mode_e MODE = MODE_BINARY
) (
    input  digit_t q,
    output digit_t tog
);
    localparam digit_t TERM = terminal_of(MODE);

    digit_t low_ones;

    for (genvar i = 0; i < DIGIT_W; i++) begin : g_low
        if (i == 0) begin : g_lsb
            assign low_ones[i] = 1'b1;
        end else begin : g_upper
            assign low_ones[i] = &q[i-1:0];
        end
    end

    if (MODE == MODE_DECADE) begin : g_decade
        // at 9, flip exactly the bits that are set so the digit lands on 0
        assign tog = (q == TERM) ? q : low_ones;
    end else begin : g_binary
        assign tog = low_ones;
    end
endmodule

// File: rtl/cnt_tff_bank.sv
`timescale 1ns/1ps
module cnt_tff_bank
    import cnt_pkg::*;
(
    input  logic       clk,
    input  step_ctrl_t ctrl,
    input  digit_t     tog,
    output digit_t     q
);
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_stage
        logic bit_q;
        always_ff @(posedge clk) begin
            if (ctrl.clear) begin
                bit_q <= 1'b0;
            end else if (ctrl.advance && tog[i]) begin
                bit_q <= ~bit_q;
            end
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/cnt_term_detect.sv
`timescale 1ns/1ps
module cnt_term_detect
    import cnt_pkg::*;
#(
    parameter count_mode_e MODE = MODE_BINARY
) (
    input  digit_t q,
    input  logic   en_chain,
    output logic   carry
);
    logic at_term;

    if (MODE == MODE_DECADE) begin : g_decade
        // only 0..9 are reachable, so bits 3 and 0 alone identify 9
        assign at_term = q[3] & q[0];
    end else begin : g_binary
        assign at_term = &q;
    end

    assign carry = en_chain & at_term;
endmodule

// File: rtl/cascade_counter.sv
`timescale 1ns/1ps
module cascade_counter
    import cnt_pkg::*;
#(
    parameter count_mode_e MODE = MODE_BINARY
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               en_par,
    input  logic               en_chain,
    output logic [DIGIT_W-1:0] count,
    output logic               carry_out
);
    step_ctrl_t ctrl;
    digit_t     q;
    digit_t     tog;

    cnt_ctrl u_ctrl (
        .rst      (rst),
        .clr_n    (clr_n),
        .en_par   (en_par),
        .en_chain (en_chain),
        .ctrl     (ctrl)
    );

    cnt_toggle_gen #(.MODE(MODE)) u_tog (
        .q   (q),
        .tog (tog)
    );

    cnt_tff_bank u_bank (
        .clk  (clk),
        .ctrl (ctrl),
        .tog  (tog),
        .q    (q)
    );

    cnt_term_detect #(.MODE(MODE)) u_term (
        .q        (q),
        .en_chain (en_chain),
        .carry    (carry_out)
    );

    assign count = q;
endmodule

// File: rtl/cascade_counter_chk.sv
`timescale 1ns/1ps
module cascade_counter_chk
    import cnt_pkg::*;
#(
    parameter count_mode_e MODE = MODE_BINARY
) (
    input logic               clk,
    input logic               rst,
    input logic               clr_n,
    input logic               en_par,
    input logic               en_chain,
    input logic [DIGIT_W-1:0] count,
    input logic               carry_out
);
    localparam digit_t TERM = terminal_of(MODE);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    function automatic digit_t succ(digit_t v);
        return (v == TERM) ? '0 : digit_t'(v + 1'b1);
    endfunction

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> count == '0);

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> count == '0);

    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_n && en_par && en_chain) |=> count == succ($past(count)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !(en_par && en_chain)) |=> $stable(count));

    if (MODE == MODE_DECADE) begin : g_dec
        assert_range_R5: assert property (@(posedge clk) disable iff (rst)
            count <= TERM);
    end

    assert_carry_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !en_chain |-> !carry_out);

    assert_carry_term_R6: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> count == TERM);

    assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (carry_out && en_par && clr_n) |=> count == '0);
endmodule

bind cascade_counter cascade_counter_chk #(.MODE(MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .en_par    (en_par),
    .en_chain  (en_chain),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/test_cascade_counter.sv
`timescale 1ns/1ps
module test_cascade_counter;
    import cnt_pkg::*;

    logic clk = 1'b0;
    logic rst, clr_n, en_par, en_t;
    logic [3:0] bin_lo, bin_hi, dec_lo, dec_hi;
    logic bin_lo_c, bin_hi_c, dec_lo_c, dec_hi_c;

    int checks = 0;
    int fails  = 0;
    int bin_m  = 0;
    int dec_m  = 0;
    bit live   = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cascade_counter #(.MODE(MODE_BINARY)) i_cascade_counter (
        .clk(clk), .rst(rst), .clr_n(clr_n), .en_par(en_par), .en_chain(en_t),
        .count(bin_lo), .carry_out(bin_lo_c));
    cascade_counter #(.MODE(MODE_BINARY)) i_bin_hi (
        .clk(clk), .rst(rst), .clr_n(clr_n), .en_par(en_par), .en_chain(bin_lo_c),
        .count(bin_hi), .carry_out(bin_hi_c));
    cascade_counter #(.MODE(MODE_DECADE)) i_dec_lo (
        .clk(clk), .rst(rst), .clr_n(clr_n), .en_par(en_par), .en_chain(en_t),
        .count(dec_lo), .carry_out(dec_lo_c));
    cascade_counter #(.MODE(MODE_DECADE)) i_dec_hi (
        .clk(clk), .rst(rst), .clr_n(clr_n), .en_par(en_par), .en_chain(dec_lo_c),
        .count(dec_hi), .carry_out(dec_hi_c));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_val(int v, int modulus, bit r, bit c, bit p, bit t);
        if (r || !c) return 0;
        if (p && t) return (v + 1) % modulus;
        return v;
    endfunction

    task automatic step(input bit r, input bit c, input bit p, input bit t);
        string tag;
        rst = r; clr_n = c; en_par = p; en_t = t;
        #1;
        if (live) begin
            // R6: carry follows en_chain and terminal value, not en_par
            check("R6", int'(bin_lo_c), int'(t && (bin_m % 16) == 15));
            check("R6", int'(dec_lo_c), int'(t && (dec_m % 10) == 9));
            // R7: upper carry chained through lower carry
            check("R7", int'(bin_hi_c), int'(t && bin_m == 255));
            check("R7", int'(dec_hi_c), int'(t && dec_m == 99));
        end
        @(posedge clk);
        bin_m = next_val(bin_m, 256, r, c, p, t);
        dec_m = next_val(dec_m, 100, r, c, p, t);
        if (r) live = 1;
        @(negedge clk);
        if (!live) return;
        tag = r ? "R1" : (!c ? "R2" : ((p && t) ? "R3" : "R4"));
        check(tag,  int'(bin_lo), bin_m % 16);
        check(tag,  int'(dec_lo), dec_m % 10);
        check("R7", int'(bin_hi), bin_m / 16);
        check("R7", int'(dec_hi), dec_m / 10);
        check("R5", int'(dec_lo <= 4'd9), 1);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        rst = 1'b1; clr_n = 1'b1; en_par = 1'b0; en_t = 1'b0;
        // R1: reset state
        step(1, 1, 1, 1);
        step(1, 1, 0, 0);
        // R3: count up to binary terminal 15 (decade digit reaches 5)
        for (int i = 0; i < 15; i++) step(0, 1, 1, 1);
        // R6: en_par low with en_chain high at 15: carry high, count held (R4)
        step(0, 1, 0, 1);
        step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        // R2: clear wins over both enables
        step(0, 0, 1, 1);
        // R5 and R7: run past every wrap of both pairs
        for (int i = 0; i < 300; i++) step(0, 1, 1, 1);
        // random mix of enables, clears and rare resets
        for (int i = 0; i < 3000; i++) begin
            bit r, c, p, t;
            r = ($urandom % 200) == 0;
            c = ($urandom % 40) != 0;
            p = ($urandom % 100) < 85;
            t = ($urandom % 100) < 85;
            step(r, c, p, t);
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule